// File: doc/BRIEF.md
# Packed Masked Narrowing Conversion Unit

This block narrows a packed vector of binary32 values into binary16 values. A vector length select picks 4, 8 or 16 lanes out of a source of up to 512 bits. Lane j is converted from source bits [32j+31:32j] and written to result bits [16j+15:16j]. The per-lane converter handles IEEE rounding, denormal results, overflow saturation, NaN quieting and the five exception flags.

Around the converters, the unit decides what each destination lane receives. It can write the converted value, keep the prior contents, or write zero. The choice depends on the write mask, the merge/zero select and whether the destination is a register or memory. The unit also forms byte enables for memory stores and ORs the flags of active lanes. It detects two illegal encodings, and an illegal operation writes nothing.

The unit is a one-deep stream stage. An operation is taken when `in_valid` and `in_ready` are both high. The result stays on the outputs with `out_valid` high until `out_ready` is seen. `in_ready` is high whenever the output register is empty or being drained in the same cycle, so a consumer that holds `out_ready` high gets one operation per cycle. While `out_valid` is high and `out_ready` is low, the stage applies back-pressure: `in_ready` is low and every output holds.

Top module: `pnc_narrow_unit`

## Requirements
- R1: Lane counts are 4, 8 and 16 for `vlen_sel` 0, 1 and 2 (3 acts as 2). Lane j of `out_packed` holds the binary16 conversion of `src_vec[32j+31:32j]`. Lanes at or above the lane count are zero in `out_packed`. Exactly representable values convert with no flags.
- R2: The rounding mode is `imm_ctl[1:0]` when `imm_ctl[2]` is 0, and `global_rm` when `imm_ctl[2]` is 1. The encodings are 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. `imm_ctl[7:3]` has no effect.
- R3: A result too large for binary16 sets overflow and precision. The result is infinity for nearest-even, and for the directed mode that rounds away from zero for that sign. Otherwise it is the largest finite magnitude 0x7BFF with the source sign.
- R4: Infinities keep their sign. A NaN gives exponent 31 with the quiet bit (bit 9) set, and its payload comes from source fraction bits [21:13]. A signalling NaN (source fraction bit 22 clear) sets invalid.
- R5: Results below the binary16 normal range become denormals, with no flush to zero. Underflow is flagged when the result is tiny before rounding and inexact. A binary32 denormal source also sets the denormal flag.
- R6: With a register destination and masking in use (`masked_enc` and `mask_en` both 1), a lane whose `lane_mask` bit is 0 keeps its `dst_prior` value when `zero_masked` is 0. It becomes zero when `zero_masked` is 1.
- R7: With a register destination, `out_dst` is zero at and above bit 16·lanes, up to bit 511.
- R8: With a memory destination, lanes that are not written and every bit above the stored width keep `dst_prior`, whatever `zero_masked` is. `out_byte_en` bits 2j and 2j+1 are 1 exactly for written lanes, and `out_byte_en` is all zero for register destinations.
- R9: With `masked_enc` 0, the encoding is unmasked: every lane within the vector length is written and `lane_mask` is ignored.
- R10: `out_flags` is {invalid, denormal, overflow, underflow, precision} from bit 4 down to bit 0. It is the OR of the flags of written lanes only.
- R11: `out_illegal` is 1 when `spare_reg` differs from 4'b1111, or when `w_bit` is 1 with `masked_enc` 0. An illegal operation gives `out_dst` equal to `dst_prior`, zero byte enables and zero flags.
- R12: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold. After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted when high with in_valid |
| src_vec | input | 512 | Packed binary32 source lanes |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 bits |
| masked_enc | input | 1 | 1 = mask-capable encoding, 0 = unmasked encoding |
| mask_en | input | 1 | Write mask in use (mask-capable encoding only) |
| lane_mask | input | 16 | Per-lane write mask |
| zero_masked | input | 1 | 1 = zero masked lanes, 0 = merge (register only) |
| dst_mem | input | 1 | 1 = memory destination, 0 = register |
| dst_prior | input | 512 | Prior destination contents |
| imm_ctl | input | 8 | Rounding control byte |
| global_rm | input | 2 | Global rounding mode |
| spare_reg | input | 4 | Unused register field, must be 4'b1111 |
| w_bit | input | 1 | Width bit, must be 0 in unmasked encoding |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_packed | output | 256 | Converted binary16 lanes |
| out_dst | output | 512 | New full-width destination value |
| out_byte_en | output | 32 | Byte write enables for memory |
| out_flags | output | 5 | OR of active-lane exception flags |
| out_illegal | output | 1 | Illegal encoding detected |

## Verification
The first pattern converts every finite binary16 value of both signs, widened exactly to binary32, while the rounding control byte changes, including its unused bits. It shows that lane placement and exact conversion are right and that no rounding mode disturbs an exact result. The second pattern adds a tail below, at and above the half unit to a stride of normal values in all four modes, chosen both directly and through the global mode. It separates the tie-to-even rule from the directed modes and catches the carry into infinity at the top of the range. Fixed vectors of special, tiny and huge inputs separate saturation from infinity and the underflow and denormal flags. Random masks, priors, lengths and destination kinds then tell merge, zero, memory and unmasked behaviour apart, including signalling NaNs in masked-off lanes that must not raise invalid.

// File: rtl/pnc_pkg.sv
package pnc_pkg;
  localparam int unsigned SP_W = 32;
  localparam int unsigned HP_W = 16;
  localparam int unsigned FLAG_W = 5;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'd0,
    RM_DOWN  = 2'd1,
    RM_UP    = 2'd2,
    RM_TRUNC = 2'd3
  } rmode_t;

  typedef struct packed {
    logic inv;
    logic den;
    logic ovf;
    logic unf;
    logic inx;
  } fpflags_t;
endpackage

// File: rtl/pnc_s2h.sv
module pnc_s2h
  import pnc_pkg::*;
(
  input  logic [SP_W-1:0] a,
  input  rmode_t          rm,
  output logic [HP_W-1:0] h,
  output fpflags_t        fl
);
  logic               s;
  logic [7:0]         e8;
  logic [22:0]        m;
  logic [23:0]        sig;
  logic [7:0]         e_eff;
  logic signed [9:0]  eh;
  logic               tiny;
  logic [4:0]         sh;
  logic [35:0]        ext;
  logic [9:0]         kept;
  logic               rb, st, inx, inc, big, ovf_inf;
  logic [14:0]        mag;

  always_comb begin
    s     = a[31];
    e8    = a[30:23];
    m     = a[22:0];
    sig   = {(e8 != 8'd0), m};
    e_eff = (e8 == 8'd0) ? 8'd1 : e8;
    eh    = $signed({2'b00, e_eff}) - 10'sd112;
    tiny  = (eh < 10'sd1);
    // normal results drop 13 fraction bits; tiny ones shift further, capped
    if (!tiny)                sh = 5'd13;
    else if (e_eff < 8'd100)  sh = 5'd26;
    else                      sh = 5'(8'd126 - e_eff);
    ext  = 36'({sig, 26'b0} >> sh);
    kept = ext[35:26];
    rb   = ext[25];
    st   = |ext[24:0];
    inx  = rb | st;
    case (rm)
      RM_NEAR: inc = rb & (st | kept[0]);
      RM_DOWN: inc = inx & s;
      RM_UP:   inc = inx & ~s;
      default: inc = 1'b0;
    endcase
    mag     = {(tiny ? 5'd0 : eh[4:0]), kept} + 15'(inc);
    big     = (eh > 10'sd30) || (mag[14:10] == 5'h1f);
    case (rm)
      RM_NEAR: ovf_inf = 1'b1;
      RM_DOWN: ovf_inf = s;
      RM_UP:   ovf_inf = ~s;
      default: ovf_inf = 1'b0;
    endcase

    h  = '0;
    fl = '0;
    if (e8 == 8'hff) begin
      if (m != 23'd0) begin
        h      = {s, 5'h1f, 1'b1, m[21:13]};
        fl.inv = ~m[22];
      end else begin
        h = {s, 15'h7c00};
      end
    end else if (big) begin
      h      = {s, (ovf_inf ? 15'h7c00 : 15'h7bff)};
      fl.ovf = 1'b1;
      fl.inx = 1'b1;
    end else begin
      h      = {s, mag};
      fl.inx = inx;
      fl.unf = tiny & inx;
      fl.den = (e8 == 8'd0) && (m != 23'd0);
    end
  end
endmodule

// File: rtl/pnc_ctrl.sv
module pnc_ctrl
  import pnc_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic [1:0]       vlen_sel,
  input  logic             masked_enc,
  input  logic             mask_en,
  input  logic [LANES-1:0] lane_mask,
  input  logic [3:0]       spare_reg,
  input  logic             w_bit,
  input  logic [2:0]       rc_ctl,
  input  logic [1:0]       global_rm,
  output logic [LANES-1:0] in_vl,
  output logic [LANES-1:0] wr,
  output rmode_t           rm,
  output logic             illegal
);
  localparam int MIN_LANES = int'(LANES / 4);
  int nlanes;

  always_comb begin
    case (vlen_sel)
      2'd0:    nlanes = MIN_LANES;
      2'd1:    nlanes = 2 * MIN_LANES;
      default: nlanes = int'(LANES);
    endcase
    for (int j = 0; j < int'(LANES); j++) in_vl[j] = (j < nlanes);
    wr      = (masked_enc && mask_en) ? lane_mask : '1;
    rm      = rmode_t'(rc_ctl[2] ? global_rm : rc_ctl[1:0]);
    illegal = (spare_reg != 4'hf) || (!masked_enc && w_bit);
  end
endmodule

// File: rtl/pnc_lane.sv
module pnc_lane
  import pnc_pkg::*;
(
  input  logic [SP_W-1:0]   src,
  input  logic [HP_W-1:0]   prior,
  input  logic              in_vl,
  input  logic              wr,
  input  logic              zero_masked,
  input  logic              is_mem,
  input  rmode_t            rm,
  output logic [HP_W-1:0]   packed_h,
  output logic [HP_W-1:0]   dst_h,
  output logic [1:0]        be,
  output logic [FLAG_W-1:0] fl
);
  logic [HP_W-1:0] cvt;
  fpflags_t        cfl;

  pnc_s2h u_cvt (
    .a  (src),
    .rm (rm),
    .h  (cvt),
    .fl (cfl)
  );

  always_comb begin
    packed_h = in_vl ? cvt : '0;
    if (in_vl && wr)                  dst_h = cvt;
    else if (is_mem)                  dst_h = prior;
    else if (!in_vl || zero_masked)   dst_h = '0;
    else                              dst_h = prior;
    be = {2{is_mem & in_vl & wr}};
    fl = (in_vl && wr) ? cfl : '0;
  end
endmodule

// File: rtl/pnc_narrow_unit.sv
module pnc_narrow_unit
  import pnc_pkg::*;
#(
  parameter int unsigned MAX_W = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [MAX_W-1:0]        src_vec,
  input  logic [1:0]              vlen_sel,
  input  logic                    masked_enc,
  input  logic                    mask_en,
  input  logic [MAX_W/32-1:0]     lane_mask,
  input  logic                    zero_masked,
  input  logic                    dst_mem,
  input  logic [MAX_W-1:0]        dst_prior,
  input  logic [7:0]              imm_ctl,
  input  logic [1:0]              global_rm,
  input  logic [3:0]              spare_reg,
  input  logic                    w_bit,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [MAX_W/2-1:0]      out_packed,
  output logic [MAX_W-1:0]        out_dst,
  output logic [MAX_W/16-1:0]     out_byte_en,
  output logic [FLAG_W-1:0]       out_flags,
  output logic                    out_illegal
);
  localparam int unsigned LANES  = MAX_W / SP_W;
  localparam int unsigned HALF_W = MAX_W / 2;
  localparam int unsigned BE_W   = HALF_W / 8;

  logic [LANES-1:0]  in_vl, wr;
  rmode_t            rm;
  logic              illegal;
  logic [HALF_W-1:0] pk_d, dl_d;
  logic [BE_W-1:0]   be_d, be_o;
  logic [FLAG_W-1:0] lfl [LANES];
  logic [FLAG_W-1:0] flor, fl_o;
  logic [MAX_W-1:0]  dst_d;
  logic              take;
  logic              unused_imm_hi;

  assign unused_imm_hi = ^imm_ctl[7:3];

  pnc_ctrl #(.LANES(LANES)) u_ctrl (
    .vlen_sel   (vlen_sel),
    .masked_enc (masked_enc),
    .mask_en    (mask_en),
    .lane_mask  (lane_mask),
    .spare_reg  (spare_reg),
    .w_bit      (w_bit),
    .rc_ctl     (imm_ctl[2:0]),
    .global_rm  (global_rm),
    .in_vl      (in_vl),
    .wr         (wr),
    .rm         (rm),
    .illegal    (illegal)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    pnc_lane u_lane (
      .src         (src_vec[SP_W*j +: SP_W]),
      .prior       (dst_prior[HP_W*j +: HP_W]),
      .in_vl       (in_vl[j]),
      .wr          (wr[j]),
      .zero_masked (zero_masked),
      .is_mem      (dst_mem),
      .rm          (rm),
      .packed_h    (pk_d[HP_W*j +: HP_W]),
      .dst_h       (dl_d[HP_W*j +: HP_W]),
      .be          (be_d[2*j +: 2]),
      .fl          (lfl[j])
    );

    assert_be_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_byte_en[2*j] == out_byte_en[2*j+1]));
  end

  always_comb begin
    flor = '0;
    for (int j = 0; j < int'(LANES); j++) flor = flor | lfl[j];
  end

  always_comb begin
    if (illegal) begin
      dst_d = dst_prior;
      be_o  = '0;
      fl_o  = '0;
    end else begin
      dst_d[HALF_W-1:0]     = dl_d;
      dst_d[MAX_W-1:HALF_W] = dst_mem ? dst_prior[MAX_W-1:HALF_W] : '0;
      be_o                  = be_d;
      fl_o                  = flor;
    end
  end

  // one-deep output stage
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_packed  <= pk_d;
      out_dst     <= dst_d;
      out_byte_en <= be_o;
      out_flags   <= fl_o;
      out_illegal <= illegal;
    end
  end

  assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_packed)
      && $stable(out_flags) && $stable(out_byte_en) && $stable(out_illegal));

  assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> (out_byte_en == '0) && (out_flags == '0));

  assert_reg_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !dst_mem && (spare_reg == 4'hf) && (masked_enc || !w_bit)
      |=> out_dst[MAX_W-1:HALF_W] == '0);

  assert_mem_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && dst_mem |=> out_dst[MAX_W-1:HALF_W] == $past(dst_prior[MAX_W-1:HALF_W]));
endmodule

// File: tb/sim_pnc_narrow_unit.sv
`timescale 1ns/1ps
module sim_pnc_narrow_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         in_valid, in_ready, out_valid, out_ready;
  logic [511:0] src, prior, o_dst;
  logic [1:0]   vlen, grm;
  logic         menc, men, zmode, mem, wbit, o_ill;
  logic [15:0]  wmask;
  logic [7:0]   imm;
  logic [3:0]   spare;
  logic [255:0] o_pk;
  logic [31:0]  o_be;
  logic [4:0]   o_fl;

  pnc_narrow_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src), .vlen_sel(vlen), .masked_enc(menc), .mask_en(men),
    .lane_mask(wmask), .zero_masked(zmode), .dst_mem(mem), .dst_prior(prior),
    .imm_ctl(imm), .global_rm(grm), .spare_reg(spare), .w_bit(wbit),
    .out_valid(out_valid), .out_ready(out_ready), .out_packed(o_pk),
    .out_dst(o_dst), .out_byte_en(o_be), .out_flags(o_fl), .out_illegal(o_ill)
  );

  localparam logic [4:0] F_INV = 5'b10000, F_DEN = 5'b01000, F_OVF = 5'b00100,
                         F_UNF = 5'b00010, F_INX = 5'b00001;

  int n_run = 0, n_fail = 0;
  logic [15:0] lh [16];
  logic [4:0]  lf [16];

  function automatic logic [31:0] widen(input logic [15:0] h);
    logic [22:0] fr;
    if (h[14:10] != 5'd0) return {h[15], 8'(h[14:10]) + 8'd112, h[9:0], 13'b0};
    for (int p = 9; p >= 0; p--)
      if (h[p]) begin
        fr = 23'(h[9:0]) << (23 - p);
        return {h[15], 8'(p + 103), fr};
      end
    return {h[15], 31'b0};
  endfunction

  task automatic defaults();
    vlen = 2'd2; menc = 1'b1; men = 1'b0; wmask = '1; zmode = 1'b0; mem = 1'b0;
    prior = '0; imm = '0; grm = '0; spare = 4'hf; wbit = 1'b0; src = '0;
    for (int j = 0; j < 16; j++) begin lh[j] = '0; lf[j] = '0; end
  endtask

  task automatic check_out(input string tag);
    logic [255:0] e_pk; logic [511:0] e_dst; logic [31:0] e_be; logic [4:0] e_fl;
    logic w, inl, ill;
    int nl;
    nl  = (vlen == 2'd0) ? 4 : (vlen == 2'd1) ? 8 : 16;
    ill = (spare != 4'hf) || (!menc && wbit);
    e_pk = '0; e_be = '0; e_fl = '0;
    e_dst = ill ? prior : {(mem ? prior[511:256] : 256'b0), 256'b0};
    for (int j = 0; j < 16; j++) begin
      inl = (j < nl);
      w   = (menc && men) ? wmask[j] : 1'b1;
      if (inl) e_pk[16*j +: 16] = lh[j];
      if (!ill) begin
        if (inl && w) begin
          e_dst[16*j +: 16] = lh[j];
          e_fl = e_fl | lf[j];
          if (mem) e_be[2*j +: 2] = 2'b11;
        end else if (mem || (inl && !zmode)) e_dst[16*j +: 16] = prior[16*j +: 16];
      end
    end
    n_run++;
    if (o_pk !== e_pk || o_dst !== e_dst || o_be !== e_be || o_fl !== e_fl || o_ill !== ill) begin
      n_fail++;
      $display("FAIL %s: packed %h exp %h | dst %h exp %h | be %h exp %h | flags %b exp %b | illegal %b exp %b",
               tag, o_pk, e_pk, o_dst, e_dst, o_be, e_be, o_fl, e_fl, o_ill, ill);
    end
  endtask

  task automatic xact(input string tag, input int stall);
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    n_run++;
    if (out_valid !== 1'b1) begin
      n_fail++; $display("FAIL R12 %s: out_valid %b exp 1", tag, out_valid);
    end
    check_out(tag);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      n_run++;
      if (in_ready !== 1'b0 || out_valid !== 1'b1) begin
        n_fail++; $display("FAIL R12 %s stall: in_ready %b exp 0 out_valid %b exp 1", tag, in_ready, out_valid);
      end
      check_out({tag, " R12 stall hold"});
    end
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic set_lane(input int j, input logic [31:0] s32, input logic [15:0] h, input logic [4:0] f);
    src[32*j +: 32] = s32; lh[j] = h; lf[j] = f;
  endtask

  function automatic logic [15:0] rand_half();
    logic [31:0] r;
    logic [14:0] m;
    r = $urandom;
    m = r[14:0];
    if (m >= 15'h7c00) m = m - 15'h7c00;
    return {r[15], m};
  endfunction

  logic [15:0] sp_h [4][16];
  logic [31:0] sp_s [16];
  logic [4:0]  sp_f [16];

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ln;
    logic [15:0] h, r;
    logic [12:0] tl;
    logic sg, inc;
    in_valid = 1'b0; out_ready = 1'b0;
    defaults();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++; $display("FAIL R12 reset: out_valid %b in_ready %b exp 0 1", out_valid, in_ready);
    end

    // R1 R2 R5: every finite binary16 value, exact, under shifting control bytes
    ln = 0;
    for (int n = 0; n < 2 * 32'h7c00; n++) begin
      h = {n[0], 15'(n >> 1)};
      set_lane(ln, widen(h), h, 5'b0);
      ln++;
      if (ln == 16) begin
        imm = 8'(n * 37); grm = 2'(n >> 4);
        xact("R1 R2 R5 exact sweep", ((n >> 4) % 97 == 0) ? 2 : 0);
        ln = 0;
      end
    end

    // R2 R3: rounding of tails, mode chosen directly or through global_rm
    defaults();
    for (int md = 0; md < 4; md++)
      for (int t = 0; t < 3; t++) begin
        tl = (t == 0) ? 13'h0001 : (t == 1) ? 13'h1000 : 13'h1001;
        if (t == 1) begin imm = {5'b10110, 1'b1, 2'(~md)}; grm = 2'(md); end
        else begin imm = {5'b01001, 1'b0, 2'(md)}; grm = 2'(~md); end
        ln = 0;
        for (int k = 0; 16'h7bff - 7 * k >= 16'h0400; k++) begin
          sg = ln[0];
          h  = 16'(16'h7bff - 7 * k);
          case (md)
            0: inc = (tl > 13'h1000) || (tl == 13'h1000 && h[0]);
            1: inc = sg;
            2: inc = !sg;
            default: inc = 1'b0;
          endcase
          r = h + 16'(inc);
          set_lane(ln, widen({sg, h[14:0]}) | 32'(tl), {sg, r[14:0]},
                   F_INX | ((r == 16'h7c00) ? F_OVF : 5'b0));
          ln++;
          if (ln == 16) begin xact($sformatf("R2 R3 round mode %0d tail %h", md, tl), 0); ln = 0; end
        end
        if (ln > 0) begin
          for (int j = ln; j < 16; j++) set_lane(j, 32'b0, 16'b0, 5'b0);
          xact("R2 R3 round flush", 0);
        end
      end

    // R3 R4 R5: special, huge and tiny inputs under each mode
    sp_s = '{32'h7f800000, 32'hff800000, 32'h7fc00000, 32'h7f800001, 32'h7fa00000, 32'hffc00000,
             32'h7f7fffff, 32'hff7fffff, 32'h00000001, 32'h80000001, 32'h33000000, 32'h33000001,
             32'h47800000, 32'h477fe000, 32'h477ff000, 32'h38800000};
    sp_f = '{5'b0, 5'b0, 5'b0, F_INV, F_INV, 5'b0, F_OVF|F_INX, F_OVF|F_INX, F_DEN|F_UNF|F_INX,
             F_DEN|F_UNF|F_INX, F_UNF|F_INX, F_UNF|F_INX, F_OVF|F_INX, 5'b0, F_OVF|F_INX, 5'b0};
    sp_h[0] = '{16'h7c00,16'hfc00,16'h7e00,16'h7e00,16'h7f00,16'hfe00,16'h7c00,16'hfc00,
                16'h0000,16'h8000,16'h0000,16'h0001,16'h7c00,16'h7bff,16'h7c00,16'h0400};
    sp_h[1] = '{16'h7c00,16'hfc00,16'h7e00,16'h7e00,16'h7f00,16'hfe00,16'h7bff,16'hfc00,
                16'h0000,16'h8001,16'h0000,16'h0000,16'h7bff,16'h7bff,16'h7bff,16'h0400};
    sp_h[2] = '{16'h7c00,16'hfc00,16'h7e00,16'h7e00,16'h7f00,16'hfe00,16'h7c00,16'hfbff,
                16'h0001,16'h8000,16'h0001,16'h0001,16'h7c00,16'h7bff,16'h7c00,16'h0400};
    sp_h[3] = '{16'h7c00,16'hfc00,16'h7e00,16'h7e00,16'h7f00,16'hfe00,16'h7bff,16'hfbff,
                16'h0000,16'h8000,16'h0000,16'h0000,16'h7bff,16'h7bff,16'h7bff,16'h0400};
    for (int md = 0; md < 4; md++) begin
      defaults();
      imm = 8'(md);
      for (int j = 0; j < 16; j++)
        set_lane(j, sp_s[j], sp_h[md][j],
                 (j == 14 && md[0]) ? F_INX : sp_f[j]);
      xact($sformatf("R3 R4 R5 specials mode %0d", md), 0);
    end

    // R6 R7 R8 R9 R10: masks, priors, lengths, destination kinds
    for (int t = 0; t < 96; t++) begin
      defaults();
      menc  = (t / 12) % 2 == 0;
      vlen  = menc ? 2'(t % 3) : 2'(t % 2);
      mem   = (t / 3) % 2 == 1;
      zmode = (t / 6) % 2 == 1;
      men   = 1'b1;
      wmask = 16'($urandom);
      imm   = 8'($urandom);
      for (int k = 0; k < 16; k++) prior[32*k +: 32] = $urandom;
      for (int j = 0; j < 16; j++) begin
        if (j % 5 == 3) set_lane(j, 32'h7f800001, 16'h7e00, F_INV);
        else begin h = rand_half(); set_lane(j, widen(h), h, 5'b0); end
      end
      xact($sformatf("R6 R7 R8 R9 R10 mask t=%0d", t), t % 3);
    end

    // R11: illegal encodings, plus W ignored in the mask-capable encoding
    for (int t = 0; t < 6; t++) begin
      defaults();
      men = 1'b1; wmask = 16'($urandom); mem = t[0];
      for (int k = 0; k < 16; k++) prior[32*k +: 32] = $urandom;
      for (int j = 0; j < 16; j++) set_lane(j, 32'h7f800001, 16'h7e00, F_INV);
      case (t / 2)
        0: spare = 4'he;
        1: begin menc = 1'b0; vlen = 2'd1; wbit = 1'b1; end
        default: wbit = 1'b1;
      endcase
      xact($sformatf("R11 encoding t=%0d", t), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule